// File: doc/BRIEF.md
# Address-Modifier Decoding Bus Slave

This block answers the target side of an asynchronous strobe/acknowledge bus. A master presents an address, a 6-bit address modifier, a direction flag and a long-word flag, then lowers the address strobe followed by one or both data strobes. The slave passes the strobes through a synchronizer and decodes the modifier. The decode yields the address space (16, 24 or 32 significant bits), whether the access is privileged, and whether it starts a block transfer. The significant address bits are then compared against the base of a small register window that belongs to that space.

If the access is served, the slave drives the acknowledge line low. It writes into or reads from its internal register file with byte-lane granularity. If the access cannot be served, it drives the bus-error line low instead. Either response is held until both data strobes have returned high.

In a block transfer, only the first data cycle uses the address bus. Each later data cycle under the same address strobe goes to an address that the slave keeps itself. That address advances by the width of each acknowledged cycle.

Top module: `strobeSlave`

## Requirements
- R1: After reset, `dtackN` and `berrN` are both high and `dataOut` is zero.
- R2: The supported modifier codes are:
  - 0x2D and 0x29, which select the 16-bit space.
  - 0x3F, 0x3E, 0x3D, 0x3B, 0x3A and 0x39, which select the 24-bit space.
  - 0x0F, 0x0E, 0x0D, 0x0B, 0x0A and 0x09, which select the 32-bit space.

  Any other code gives a bus error, and a write that gets a bus error leaves the register file unchanged.
- R3: Modifier bit 2 set marks a privileged code. The 16-bit window accepts privileged codes only, so 0x29 gives a bus error. The 24-bit and 32-bit windows accept both kinds of code.
- R4: Only the low 16, 24 or 32 address bits count, depending on the space. An access hits when those bits, divided by the window size (DEPTH×4 bytes), equal the space's base divided by the same size; otherwise it gives a bus error.
- R5: Transfer width is set by the strobes and `lwordN`:
  - Both data strobes low with `lwordN` low is a 4-byte transfer.
  - Both data strobes low with `lwordN` high is a 2-byte transfer.
  - One data strobe low with `lwordN` high is a 1-byte transfer. Here `ds0N` alone selects the odd byte and `ds1N` alone the even byte.

  Data is right-justified on the data buses, and byte offset 0 of a word is bits 7:0.
- R6: Any of the following gives a bus error: a single data strobe with `lwordN` low, a 4-byte transfer whose address bit 1 is set, or a block-mode cursor that is not aligned to the width.
- R7: Written data is returned by later reads of the same bytes. `dataOut` is non-zero only while `dtackN` is low for a read.
- R8: A response starts only after both address strobe and a data strobe have been seen low. It stays asserted while any data strobe is low, and it ends after both data strobes are high. `dtackN` and `berrN` are never low together.
- R9: After an acknowledged cycle with a block code (modifier bits 1:0 = 11), each further data cycle under the same address strobe ignores `addrIn`. It uses the previous offset plus the previous width in bytes.
- R10: A block cycle whose cursor has passed the end of the window gives a bus error and ends the block. The next data cycle then takes its address from `addrIn`.
- R11: With a non-block code, each data cycle under one held address strobe decodes the address bus afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| addrIn | input | 31 | Address bits 31:1 |
| amIn | input | 6 | Address modifier |
| writeIn | input | 1 | 1 = write, 0 = read |
| asN | input | 1 | Address strobe, active low, asynchronous |
| ds0N | input | 1 | Data strobe 0 (odd byte), active low, asynchronous |
| ds1N | input | 1 | Data strobe 1 (even byte), active low, asynchronous |
| lwordN | input | 1 | Long-word flag, active low |
| dataIn | input | 32 | Write data, right-justified |
| dataOut | output | 32 | Read data, right-justified, zero when not acknowledging a read |
| dtackN | output | 1 | Transfer acknowledge, active low |
| berrN | output | 1 | Bus error, active low |

## Verification
The bench goes after the following cases:
- Rejected modifiers and the user-mode code on the privileged-only window. A slave that decoded too loosely would acknowledge these, and the read-back would show that a rejected write had landed.
- Addresses whose upper bits are junk in the narrow spaces, and offsets just past the window. A comparator using the wrong bits would misroute these.
- Odd and even single bytes, and misaligned long words. A wrong lane map would corrupt neighbouring bytes.
- Block runs with garbage on the address bus, and a byte-wide run that walks off the window end. A slave that re-read `addrIn` or forgot to advance would store the data at the wrong offsets, and one missing the end check would wrap instead of erroring.

Random cycles of all widths and codes cover the remaining mix, and each one is checked for a held response until the strobes are released.

// File: rtl/strobeSlavePkg.sv
package strobeSlavePkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RESP,
    S_BWAIT
  } slaveStateT;

  // control -> datapath strobes
  typedef struct packed {
    logic evalFirst;  // decode a cycle using the address bus
    logic evalNext;   // decode a block cycle using the cursor
    logic respOn;     // acknowledge phase active
  } ctrlStrobeT;

endpackage

// File: rtl/syncBits.sv
module syncBits #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] shiftQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shiftQ <= '1;
      else       shiftQ <= {shiftQ[STAGES-2:0], rawIn[b]};
    end
    assign syncOut[b] = shiftQ[STAGES-1];
  end

endmodule

// File: rtl/strobeCtrl.sv
module strobeCtrl
  import strobeSlavePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       asSyncN,
  input  logic       ds0SyncN,
  input  logic       ds1SyncN,
  input  logic       okNow,
  input  logic       blockNow,
  output ctrlStrobeT strobes,
  output logic       dtackN,
  output logic       berrN,
  output logic       asAct,
  output logic       dsAct
);

  slaveStateT stateQ;
  logic       okQ;
  logic       blkQ;

  assign asAct = !asSyncN;
  assign dsAct = !ds0SyncN || !ds1SyncN;

  always_comb begin
    strobes.evalFirst = (stateQ == S_IDLE)  && asAct && dsAct;
    strobes.evalNext  = (stateQ == S_BWAIT) && asAct && dsAct;
    strobes.respOn    = (stateQ == S_RESP)  && okQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      okQ    <= 1'b0;
      blkQ   <= 1'b0;
    end else begin
      unique case (stateQ)
        S_IDLE: if (strobes.evalFirst) begin
          okQ    <= okNow;
          blkQ   <= okNow && blockNow;
          stateQ <= S_RESP;
        end
        S_RESP: if (!dsAct) begin
          stateQ <= (blkQ && asAct) ? S_BWAIT : S_IDLE;
        end
        S_BWAIT: begin
          if (!asAct) begin
            stateQ <= S_IDLE;
          end else if (dsAct) begin
            okQ    <= okNow;
            blkQ   <= okNow;
            stateQ <= S_RESP;
          end
        end
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  assign dtackN = !((stateQ == S_RESP) && okQ);
  assign berrN  = !((stateQ == S_RESP) && !okQ);

endmodule

// File: rtl/strobeDatapath.sv
module strobeDatapath
  import strobeSlavePkg::*;
#(
  parameter int          DEPTH     = 8,
  parameter logic [31:0] A16_BASE  = 32'h0000_4000,
  parameter logic [31:0] A24_BASE  = 32'h0020_0000,
  parameter logic [31:0] A32_BASE  = 32'h8000_0000,
  parameter logic [2:0]  PRIV_ONLY = 3'b001
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobeT  strobes,
  input  logic [31:1] addrIn,
  input  logic [5:0]  amIn,
  input  logic        writeIn,
  input  logic        ds0SyncN,
  input  logic        ds1SyncN,
  input  logic        lwordN,
  input  logic [31:0] dataIn,
  output logic        okNow,
  output logic        blockNow,
  output logic [31:0] dataOut
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int OFF_W = IDX_W + 2;

  logic [31:0]      regs [DEPTH];
  logic [OFF_W:0]   cursorQ;
  logic [31:0]      rdQ;

  logic             amValid;
  logic [1:0]       amSpace;
  logic             amPriv;
  logic [31:1]      sigAddr;
  logic [31:1]      baseSel;
  logic             hit;
  logic             privOk;
  logic             bothDs;
  logic             oneDs;
  logic [2:0]       widthBytes;
  logic [OFF_W-1:0] firstOff;
  logic [OFF_W-1:0] off;
  logic             inWin;
  logic             aligned;
  logic             doEval;
  logic [1:0]       lane;
  logic [3:0]       wrMask;
  logic [31:0]      wrWord;
  logic [31:0]      widthMask;
  logic [IDX_W-1:0] idx;

  // modifier decode: space 0 = 16-bit, 1 = 24-bit, 2 = 32-bit
  always_comb begin
    amValid = 1'b1;
    amSpace = 2'd2;
    unique case (amIn)
      6'h2D, 6'h29:                             amSpace = 2'd0;
      6'h3F, 6'h3E, 6'h3D, 6'h3B, 6'h3A, 6'h39: amSpace = 2'd1;
      6'h0F, 6'h0E, 6'h0D, 6'h0B, 6'h0A, 6'h09: amSpace = 2'd2;
      default:                                  amValid = 1'b0;
    endcase
  end
  assign amPriv   = amIn[2];
  assign blockNow = amValid && (amIn[1:0] == 2'b11);
  assign privOk   = amPriv || !PRIV_ONLY[amSpace];

  always_comb begin
    unique case (amSpace)
      2'd0:    begin sigAddr = {16'h0, addrIn[15:1]}; baseSel = {16'h0, A16_BASE[15:1]}; end
      2'd1:    begin sigAddr = {8'h0,  addrIn[23:1]}; baseSel = {8'h0,  A24_BASE[23:1]}; end
      default: begin sigAddr = addrIn;                baseSel = A32_BASE[31:1];          end
    endcase
  end
  assign hit = (sigAddr[31:OFF_W] == baseSel[31:OFF_W]);

  // width from strobes
  assign bothDs = !ds0SyncN && !ds1SyncN;
  assign oneDs  = ds0SyncN ^ ds1SyncN;
  always_comb begin
    if (bothDs)             widthBytes = lwordN ? 3'd2 : 3'd4;
    else if (oneDs && lwordN) widthBytes = 3'd1;
    else                    widthBytes = 3'd0;
  end

  assign firstOff = {sigAddr[OFF_W-1:1], oneDs && !ds0SyncN};
  assign off      = strobes.evalNext ? cursorQ[OFF_W-1:0] : firstOff;
  assign inWin    = strobes.evalNext ? !cursorQ[OFF_W] : (amValid && privOk && hit);

  always_comb begin
    unique case (widthBytes)
      3'd4:    aligned = (off[1:0] == 2'b00);
      3'd2:    aligned = !off[0];
      default: aligned = 1'b1;
    endcase
  end

  assign okNow  = (widthBytes != 3'd0) && aligned && inWin;
  assign doEval = strobes.evalFirst || strobes.evalNext;

  // lane steering
  assign lane = off[1:0];
  assign idx  = off[OFF_W-1:2];
  always_comb begin
    unique case (widthBytes)
      3'd4:    begin wrMask = 4'b1111; widthMask = 32'hFFFF_FFFF; end
      3'd2:    begin wrMask = 4'b0011 << lane; widthMask = 32'h0000_FFFF; end
      default: begin wrMask = 4'b0001 << lane; widthMask = 32'h0000_00FF; end
    endcase
  end
  assign wrWord = dataIn << {lane, 3'b000};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
      cursorQ <= '0;
      rdQ     <= '0;
    end else if (doEval) begin
      rdQ <= '0;
      if (okNow) begin
        cursorQ <= {1'b0, off} + (OFF_W+1)'(widthBytes);
        if (writeIn) begin
          for (int k = 0; k < 4; k++)
            if (wrMask[k]) regs[idx][8*k +: 8] <= wrWord[8*k +: 8];
        end else begin
          rdQ <= (regs[idx] >> {lane, 3'b000}) & widthMask;
        end
      end
    end
  end

  assign dataOut = strobes.respOn ? rdQ : '0;

endmodule

// File: rtl/strobeSlave.sv
module strobeSlave
  import strobeSlavePkg::*;
#(
  parameter int          DEPTH     = 8,
  parameter logic [31:0] A16_BASE  = 32'h0000_4000,
  parameter logic [31:0] A24_BASE  = 32'h0020_0000,
  parameter logic [31:0] A32_BASE  = 32'h8000_0000,
  parameter logic [2:0]  PRIV_ONLY = 3'b001
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:1] addrIn,
  input  logic [5:0]  amIn,
  input  logic        writeIn,
  input  logic        asN,
  input  logic        ds0N,
  input  logic        ds1N,
  input  logic        lwordN,
  input  logic [31:0] dataIn,
  output logic [31:0] dataOut,
  output logic        dtackN,
  output logic        berrN
);

  logic [2:0] syncW;
  ctrlStrobeT strobesW;
  logic       okW;
  logic       blockW;
  logic       asActW;
  logic       dsActW;

  syncBits #(.WIDTH(3), .STAGES(2)) i_sync (
    .clk(clk), .rstN(rstN),
    .rawIn({asN, ds1N, ds0N}),
    .syncOut(syncW)
  );

  strobeCtrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .asSyncN(syncW[2]), .ds0SyncN(syncW[0]), .ds1SyncN(syncW[1]),
    .okNow(okW), .blockNow(blockW),
    .strobes(strobesW),
    .dtackN(dtackN), .berrN(berrN),
    .asAct(asActW), .dsAct(dsActW)
  );

  strobeDatapath #(
    .DEPTH(DEPTH), .A16_BASE(A16_BASE), .A24_BASE(A24_BASE),
    .A32_BASE(A32_BASE), .PRIV_ONLY(PRIV_ONLY)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobesW),
    .addrIn(addrIn), .amIn(amIn), .writeIn(writeIn),
    .ds0SyncN(syncW[0]), .ds1SyncN(syncW[1]), .lwordN(lwordN),
    .dataIn(dataIn), .okNow(okW), .blockNow(blockW), .dataOut(dataOut)
  );

endmodule

// File: rtl/strobeSlaveChk.sv
module strobeSlaveChk (
  input logic        clk,
  input logic        rstN,
  input logic        dtackN,
  input logic        berrN,
  input logic        asAct,
  input logic        dsAct,
  input logic [31:0] dataOut
);

  // R8
  resp_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!dtackN && !berrN));

  // R8
  resp_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dtackN) || $fell(berrN)) |-> ($past(dsAct) && $past(asAct)));

  // R8
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dtackN && dsAct) |=> !dtackN);

  // R8
  berr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!berrN && dsAct) |=> !berrN);

  // R8
  resp_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dtackN) || $rose(berrN)) |-> !$past(dsAct));

  // R7
  data_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataOut != 32'h0) |-> !dtackN);

endmodule

bind strobeSlave strobeSlaveChk i_chk (
  .clk(clk), .rstN(rstN), .dtackN(dtackN), .berrN(berrN),
  .asAct(asActW), .dsAct(dsActW), .dataOut(dataOut)
);

// File: tb/test_strobeSlave.sv
module test_strobeSlave;

  localparam int          CLK_PERIOD = 10;
  localparam int          DEPTH      = 8;
  localparam int          WIN        = DEPTH * 4;
  localparam logic [31:0] A16B       = 32'h0000_4000;
  localparam logic [31:0] A24B       = 32'h0020_0000;
  localparam logic [31:0] A32B       = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:1] addrIn = '0;
  logic [5:0]  amIn = '0;
  logic        writeIn = 1'b0;
  logic        asN = 1'b1;
  logic        ds0N = 1'b1;
  logic        ds1N = 1'b1;
  logic        lwordN = 1'b1;
  logic [31:0] dataIn = '0;
  logic [31:0] dataOut;
  logic        dtackN;
  logic        berrN;

  int  checks = 0;
  int  failures = 0;
  logic [7:0] mem [WIN];
  bit  blkAlive = 1'b0;
  int  cur = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobeSlave #(.DEPTH(DEPTH), .A16_BASE(A16B), .A24_BASE(A24B),
                .A32_BASE(A32B), .PRIV_ONLY(3'b001)) i_strobeSlave (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .amIn(amIn), .writeIn(writeIn),
    .asN(asN), .ds0N(ds0N), .ds1N(ds1N), .lwordN(lwordN), .dataIn(dataIn),
    .dataOut(dataOut), .dtackN(dtackN), .berrN(berrN)
  );

  task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int spaceOf(input logic [5:0] am);
    case (am)
      6'h2D, 6'h29: return 0;
      6'h3F, 6'h3E, 6'h3D, 6'h3B, 6'h3A, 6'h39: return 1;
      6'h0F, 6'h0E, 6'h0D, 6'h0B, 6'h0A, 6'h09: return 2;
      default: return -1;
    endcase
  endfunction

  function automatic bit widthOk(input int w, input int off);
    if (w == 4) return (off % 4) == 0;
    if (w == 2) return (off % 2) == 0;
    return w == 1;
  endfunction

  function automatic logic [31:0] memRead(input int off, input int w);
    logic [31:0] v = '0;
    for (int i = 0; i < w; i++) v[8*i +: 8] = mem[off+i];
    return v;
  endfunction

  // one data cycle: drive, wait for response, check hold and release
  task automatic doCycle(input logic [31:0] busAddr, input logic [5:0] am, input bit wr,
                         input int w, input bit odd, input logic [31:0] data,
                         input string tag, output bit ack, output bit err, output logic [31:0] rd);
    bit seen = 1'b0;
    addrIn = busAddr[31:1]; amIn = am; writeIn = wr; dataIn = data;
    lwordN = !(w == 4 || w == 3);
    asN = 1'b0;
    @(negedge clk);
    if (w == 4 || w == 2) begin ds0N = 1'b0; ds1N = 1'b0; end
    else if (odd)         begin ds0N = 1'b0; end
    else                  begin ds1N = 1'b0; end
    for (int i = 0; i < 12 && !seen; i++) begin
      @(negedge clk);
      if (!dtackN || !berrN) seen = 1'b1;
    end
    chk(seen, {tag, " R8 response"}, {31'h0, seen}, 32'h1);
    ack = !dtackN; err = !berrN; rd = dataOut;
    ds0N = 1'b1; ds1N = 1'b1;
    @(negedge clk);
    chk((!dtackN) == ack && (!berrN) == err, {tag, " R8 held"}, {30'h0, dtackN, berrN}, {30'h0, !ack, !err});
    seen = 1'b0;
    for (int i = 0; i < 8 && !seen; i++) begin
      @(negedge clk);
      if (dtackN && berrN) seen = 1'b1;
    end
    chk(seen, {tag, " R8 release"}, {31'h0, seen}, 32'h1);
  endtask

  task automatic asRelease();
    asN = 1'b1;
    repeat (4) @(negedge clk);
    blkAlive = 1'b0;
  endtask

  // cycle that takes its address from the bus
  task automatic xferFirst(input logic [5:0] am, input logic [31:0] addr, input bit wr,
                           input int w, input logic [31:0] data, input string tag);
    int sp = spaceOf(am);
    logic [31:0] sig, base;
    int off;
    bit odd = addr[0];
    bit expOk, ack, err;
    logic [31:0] rd;
    sig  = (sp == 0) ? {16'h0, addr[15:0]} : (sp == 1) ? {8'h0, addr[23:0]} : addr;
    base = (sp == 0) ? A16B : (sp == 1) ? A24B : A32B;
    off  = int'(sig[4:1]) * 2 + ((w == 1) ? int'(odd) : 0);
    expOk = (sp >= 0) && (am[2] || sp != 0) && (sig[31:5] == base[31:5]) && widthOk(w, off);
    doCycle(addr, am, wr, w, odd, data, tag, ack, err, rd);
    chk(ack == expOk && err == !expOk, {tag, " ack/berr"}, {30'h0, ack, err}, {30'h0, expOk, !expOk});
    if (expOk && !wr) chk(rd == memRead(off, w), {tag, " R7 read"}, rd, memRead(off, w));
    if (!expOk || wr) chk(rd == 32'h0, {tag, " R7 idle data"}, rd, 32'h0);
    if (expOk && wr) for (int i = 0; i < w; i++) mem[off+i] = data[8*i +: 8];
    blkAlive = expOk && (am[1:0] == 2'b11) && sp >= 0;
    cur = off + w;
  endtask

  // block continuation cycle, address bus carries junk
  task automatic xferNext(input bit wr, input int w, input logic [31:0] data, input string tag);
    bit expOk, ack, err;
    logic [31:0] rd;
    expOk = blkAlive && cur < WIN && widthOk(w, cur);
    doCycle($urandom, amIn, wr, w, 1'($urandom), data, tag, ack, err, rd);
    chk(ack == expOk && err == !expOk, {tag, " ack/berr"}, {30'h0, ack, err}, {30'h0, expOk, !expOk});
    if (expOk && !wr) chk(rd == memRead(cur, w), {tag, " R9 read"}, rd, memRead(cur, w));
    if (expOk && wr) for (int i = 0; i < w; i++) mem[cur+i] = data[8*i +: 8];
    if (expOk) cur = cur + w;
    blkAlive = expOk;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [5:0] amList [16] = '{6'h3F, 6'h3E, 6'h3D, 6'h3B, 6'h3A, 6'h39, 6'h2D, 6'h29,
                                6'h0F, 6'h0E, 6'h0D, 6'h0B, 6'h0A, 6'h09, 6'h3C, 6'h2A};
    int wList [4] = '{1, 2, 4, 3};
    void'($urandom(32'd1357));
    for (int i = 0; i < WIN; i++) mem[i] = 8'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dtackN && berrN && dataOut == 0, "R1 reset", {dtackN, berrN, dataOut[29:0]}, 32'hC000_0000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(dtackN && berrN, "R1 after reset", {30'h0, dtackN, berrN}, 32'h3);

    // R7 R5 long word write/read in 32-bit space
    xferFirst(6'h0D, A32B + 4, 1, 4, 32'hA1B2_C3D4, "R7 wr32"); asRelease();
    xferFirst(6'h09, A32B + 4, 0, 4, 0, "R7 rd32"); asRelease();
    // R5 single bytes odd/even, 16-bit
    xferFirst(6'h0D, A32B + 9, 1, 1, 32'h55, "R5 odd byte"); asRelease();
    xferFirst(6'h0D, A32B + 8, 1, 1, 32'h66, "R5 even byte"); asRelease();
    xferFirst(6'h0D, A32B + 10, 1, 2, 32'hBEEF, "R5 half"); asRelease();
    xferFirst(6'h0D, A32B + 8, 0, 4, 0, "R5 word view"); asRelease();
    xferFirst(6'h0D, A32B + 7, 0, 1, 0, "R5 top byte"); asRelease();
    // R2 unsupported code, write must not land
    xferFirst(6'h3C, A24B + 4, 1, 4, 32'hDEAD_DEAD, "R2 bad code"); asRelease();
    xferFirst(6'h3D, A24B + 4, 0, 4, 0, "R2 unchanged"); asRelease();
    // R3 privilege on 16-bit window
    xferFirst(6'h29, A16B + 12, 1, 4, 32'h1111_2222, "R3 user a16"); asRelease();
    xferFirst(6'h2D, A16B + 12, 0, 4, 0, "R3 priv a16 unchanged"); asRelease();
    xferFirst(6'h39, A24B + 12, 0, 4, 0, "R3 user a24"); asRelease();
    // R4 upper bits ignored, out of window
    xferFirst(6'h2D, 32'h9ABC_0000 | A16B | 32'h10, 1, 4, 32'h0BAD_F00D, "R4 a16 junk top"); asRelease();
    xferFirst(6'h3D, 32'h7F00_0000 | A24B | 32'h10, 0, 4, 0, "R4 a24 junk top"); asRelease();
    xferFirst(6'h0D, A32B + WIN, 0, 4, 0, "R4 past window"); asRelease();
    xferFirst(6'h0D, A32B - 4, 0, 4, 0, "R4 below window"); asRelease();
    // R6 invalid combos
    xferFirst(6'h0D, A32B + 2, 0, 4, 0, "R6 misaligned long"); asRelease();
    xferFirst(6'h0D, A32B + 2, 0, 3, 0, "R6 lword single"); asRelease();
    // R9 block write with junk addresses, read back singly
    xferFirst(6'h0F, A32B + 16, 1, 4, 32'h1000_0001, "R9 blk first");
    xferNext(1, 4, 32'h2000_0002, "R9 blk next");
    xferNext(1, 2, 32'h0000_3333, "R9 blk half");
    xferNext(1, 1, 32'h0000_0044, "R9 blk byte");
    asRelease();
    for (int o = 16; o < 28; o += 4) begin
      xferFirst(6'h0D, A32B + o, 0, 4, 0, "R9 readback"); asRelease();
    end
    // R10 byte block runs off the end, then address bus used again
    xferFirst(6'h3B, A24B + 29, 1, 1, 32'h71, "R10 blk start");
    xferNext(1, 1, 32'h72, "R10 blk mid");
    xferNext(1, 1, 32'h73, "R10 blk last");
    xferNext(1, 1, 32'h74, "R10 blk over");
    xferFirst(6'h3D, A24B + 28, 0, 4, 0, "R10 fresh address");
    asRelease();
    // R11 non-block, AS held, new address each cycle
    xferFirst(6'h0D, A32B + 4, 0, 4, 0, "R11 first");
    xferFirst(6'h0D, A32B + 16, 0, 4, 0, "R11 second");
    asRelease();

    // random mix
    for (int n = 0; n < 250; n++) begin
      logic [5:0] am = amList[$urandom_range(0, 15)];
      int sp = spaceOf(am);
      int pick = $urandom_range(0, 3);
      logic [31:0] base = (pick == 0) ? A16B : (pick == 1) ? A24B : A32B;
      logic [31:0] addr;
      if (pick == 3) base = (sp == 0) ? A16B : (sp == 1) ? A24B : A32B;
      addr = base + $urandom_range(0, WIN + 8);
      if (sp == 0) addr[31:16] = 16'($urandom);
      if (sp == 1) addr[31:24] = 8'($urandom);
      xferFirst(am, addr, 1'($urandom), wList[$urandom_range(0, 3)], $urandom, "R2 R4 R5 random");
      for (int k = 0; k < 3 && blkAlive; k++)
        xferNext(1'($urandom), wList[$urandom_range(0, 2)], $urandom, "R9 random");
      asRelease();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule